// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of a synchronous DRAM burst. When a read or write command is accepted, it captures an 8-bit starting column and the active mode fields: a 3-bit length code, an ordering bit and a single-write bit. From the next cycle on it presents one column per clock on registered outputs. Each beat is qualified by a valid flag, and a last flag marks the final column of a fixed-length burst.

Fixed-length bursts stay inside the aligned block that the burst length defines. Sequential order counts through that block and wraps with no carry into higher bits. Interleave order XORs the beat index into the low bits. A full-page burst walks through all 256 columns, wraps from 255 back to 0, and runs until a stop request or a new command ends it.

A new command always restarts the burst. A stop request ends only a full-page burst. A suspend input freezes the generator in place. Illegal requests and reserved mode combinations raise a one-cycle error pulse.

Top module: `sdram_burst_colgen`

## Requirements
- R1: Length codes set the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. A command carrying 3'b100, 3'b101 or 3'b110 starts no beats, and mode_err is high in the following cycle.
- R2: burst_ilv=0 selects sequential order and burst_ilv=1 selects interleave order. Both are latched with the command.
- R3: In sequential order, beat i of a length-L burst (L = 2, 4 or 8) is `(start & ~(L-1)) | ((start + i) mod L)`. No carry leaves the aligned block.
- R4: In interleave order, beat i of a length-L burst is `start XOR i`, with i < L.
- R5: In a full-page burst, beat i is `(start + i) mod 256`. last_beat never rises, and the burst continues until a stop request or a new command.
- R6: A command sampled at a clock edge puts beat 0 on col_addr with beat_valid high right after that edge. Each later edge advances one beat. last_beat is high together with the final column. beat_valid is low after the next edge, and col_addr keeps its last value.
- R7: A command accepted while a burst is running discards that burst. It starts a fresh burst of the full length from the new column, using the new mode fields.
- R8: A stop request during a full-page burst clears beat_valid at the next edge and raises no error.
- R9: A stop request during a fixed-length burst pulses mode_err for one cycle and leaves the burst sequence unchanged. A stop request while no burst runs has no effect.
- R10: When single_write=1, a write command (cmd_write=1) gives exactly one beat. A read command under the same setting bursts at the programmed length.
- R11: Interleave order combined with full page is reserved. Such a command starts no beats and pulses mode_err. A single-write write is the exception: it is a legal one-beat access.
- R12: While suspend is high at an edge, col_addr, beat_valid and last_beat hold their values. Commands and stop requests at that edge are ignored. Suspend takes priority over a command, and a command takes priority over a stop request.
- R13: After synchronous reset, beat_valid, last_beat and mode_err are 0 and col_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Read or write command strobe |
| cmd_write | input | 1 | 1 for write, 0 for read |
| start_col | input | 8 | Starting column of the burst |
| burst_len_code | input | 3 | Burst length code |
| burst_ilv | input | 1 | 0 sequential, 1 interleave |
| single_write | input | 1 | Writes transfer one beat when set |
| stop_req | input | 1 | Burst-stop request |
| suspend | input | 1 | Freeze the burst in place |
| col_addr | output | 8 | Column address of the current beat |
| beat_valid | output | 1 | A beat is presented this cycle |
| last_beat | output | 1 | Current beat is the final one |
| mode_err | output | 1 | One-cycle pulse on illegal stop or reserved mode |

## Verification
The bench builds the block with its default 8-bit column width, which makes all 256 start columns reachable.

It sweeps every legal fixed length, both orders, both single-write settings and both directions from every start column, and checks each beat arithmetically. This exposes every wrap position inside the 2-, 4- and 8-wide blocks.

Full-page runs of more than 256 beats from several start columns cover the 255-to-0 wrap. Directed sequences then cover:
- interrupting commands
- stop requests that are legal, illegal and idle
- suspend with commands arriving while frozen
- the reserved codes

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_ONE   = 3'b000;
  localparam logic [LEN_CODE_W-1:0] LEN_TWO   = 3'b001;
  localparam logic [LEN_CODE_W-1:0] LEN_FOUR  = 3'b010;
  localparam logic [LEN_CODE_W-1:0] LEN_EIGHT = 3'b011;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE  = 3'b111;
endpackage

// File: rtl/burst_mode_dec.sv
module burst_mode_dec
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  ilv_in,
  input  logic                  single_wr,
  input  logic                  is_write,
  output logic [COL_W-1:0]      span_mask,
  output logic                  ilv,
  output logic                  full_page,
  output logic                  bad
);
  localparam logic [COL_W-1:0] MASK_ONE   = COL_W'(0);
  localparam logic [COL_W-1:0] MASK_TWO   = COL_W'(1);
  localparam logic [COL_W-1:0] MASK_FOUR  = COL_W'(3);
  localparam logic [COL_W-1:0] MASK_EIGHT = COL_W'(7);

  logic one_beat;

  always_comb begin
    one_beat  = single_wr & is_write;
    ilv       = ilv_in;
    full_page = 1'b0;
    bad       = 1'b0;
    span_mask = MASK_ONE;
    case (len_code)
      LEN_ONE:   span_mask = MASK_ONE;
      LEN_TWO:   span_mask = MASK_TWO;
      LEN_FOUR:  span_mask = MASK_FOUR;
      LEN_EIGHT: span_mask = MASK_EIGHT;
      LEN_PAGE: begin
        span_mask = '1;
        full_page = 1'b1;
      end
      default:   bad = 1'b1;
    endcase
    if (one_beat) begin
      span_mask = MASK_ONE;
      full_page = 1'b0;
    end
    if (ilv_in && full_page) bad = 1'b1;
  end
endmodule

// File: rtl/burst_addr_calc.sv
module burst_addr_calc #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] span_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] sum;
  assign sum = start + idx;

  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    logic moving;
    assign moving  = ilv ? (start[b] ^ idx[b]) : sum[b];
    assign addr[b] = span_mask[b] ? moving : start[b];
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             stop_req,
  input  logic             suspend,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] cfg_mask,
  input  logic             cfg_ilv,
  input  logic             cfg_full,
  input  logic             cfg_bad,
  output logic [COL_W-1:0] nxt_start,
  output logic [COL_W-1:0] nxt_idx,
  output logic [COL_W-1:0] nxt_mask,
  output logic             nxt_ilv,
  output logic             act_q,
  output logic             last_q,
  output logic             err_q
);
  logic [COL_W-1:0] start_q, idx_q, mask_q;
  logic             ilv_q, full_q;
  logic             act_n, full_n, err_n, last_n;

  always_comb begin
    act_n     = act_q;
    nxt_start = start_q;
    nxt_idx   = idx_q;
    nxt_mask  = mask_q;
    nxt_ilv   = ilv_q;
    full_n    = full_q;
    err_n     = 1'b0;
    if (!suspend) begin
      if (cmd_valid) begin
        if (cfg_bad) begin
          act_n = 1'b0;
          err_n = 1'b1;
        end else begin
          act_n     = 1'b1;
          nxt_start = start_col;
          nxt_idx   = '0;
          nxt_mask  = cfg_mask;
          nxt_ilv   = cfg_ilv;
          full_n    = cfg_full;
        end
      end else if (act_q) begin
        if (stop_req && full_q) begin
          act_n = 1'b0;
        end else begin
          err_n = stop_req;
          if (!full_q && idx_q == mask_q) act_n = 1'b0;
          else nxt_idx = idx_q + 1'b1;
        end
      end
    end
    last_n = act_n && !full_n && (nxt_idx == nxt_mask);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      start_q <= '0;
      idx_q   <= '0;
      mask_q  <= '0;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      act_q   <= act_n;
      last_q  <= last_n;
      err_q   <= err_n;
      start_q <= nxt_start;
      idx_q   <= nxt_idx;
      mask_q  <= nxt_mask;
      ilv_q   <= nxt_ilv;
      full_q  <= full_n;
    end
  end

  assert_span_shape_R1: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (((mask_q + 1'b1) & mask_q) == '0));
  assert_idx_in_span_R3: assert property (@(posedge clk) disable iff (rst)
    (act_q && !full_q) |-> (idx_q <= mask_q));
  assert_page_stop_R8: assert property (@(posedge clk) disable iff (rst)
    (act_q && full_q && stop_req && !cmd_valid && !suspend) |=> (!act_q && !err_q));
  assert_bad_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !suspend && cfg_bad) |=> (err_q && !act_q));
  assert_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    suspend |=> ($stable(idx_q) && $stable(act_q) && $stable(start_q)));
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cmd_valid,
  input  logic                  cmd_write,
  input  logic [COL_W-1:0]      start_col,
  input  logic [LEN_CODE_W-1:0] burst_len_code,
  input  logic                  burst_ilv,
  input  logic                  single_write,
  input  logic                  stop_req,
  input  logic                  suspend,
  output logic [COL_W-1:0]      col_addr,
  output logic                  beat_valid,
  output logic                  last_beat,
  output logic                  mode_err
);
  logic [COL_W-1:0] cfg_mask, nxt_start, nxt_idx, nxt_mask, addr_n;
  logic             cfg_ilv, cfg_full, cfg_bad, nxt_ilv;

  burst_mode_dec #(.COL_W(COL_W)) u_dec (
    .len_code  (burst_len_code),
    .ilv_in    (burst_ilv),
    .single_wr (single_write),
    .is_write  (cmd_write),
    .span_mask (cfg_mask),
    .ilv       (cfg_ilv),
    .full_page (cfg_full),
    .bad       (cfg_bad)
  );

  burst_seq #(.COL_W(COL_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .stop_req  (stop_req),
    .suspend   (suspend),
    .start_col (start_col),
    .cfg_mask  (cfg_mask),
    .cfg_ilv   (cfg_ilv),
    .cfg_full  (cfg_full),
    .cfg_bad   (cfg_bad),
    .nxt_start (nxt_start),
    .nxt_idx   (nxt_idx),
    .nxt_mask  (nxt_mask),
    .nxt_ilv   (nxt_ilv),
    .act_q     (beat_valid),
    .last_q    (last_beat),
    .err_q     (mode_err)
  );

  burst_addr_calc #(.COL_W(COL_W)) u_calc (
    .start     (nxt_start),
    .idx       (nxt_idx),
    .span_mask (nxt_mask),
    .ilv       (nxt_ilv),
    .addr      (addr_n)
  );

  always_ff @(posedge clk) begin
    if (rst) col_addr <= '0;
    else     col_addr <= addr_n;
  end

  assert_last_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (last_beat && !suspend && !cmd_valid) |=> !beat_valid);
  assert_addr_freeze_R12: assert property (@(posedge clk) disable iff (rst)
    suspend |=> ($stable(col_addr) && $stable(beat_valid) && $stable(last_beat)));
  assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (rst)
    last_beat |-> beat_valid);
endmodule

// File: tb/tb_sdram_burst_colgen.sv
module tb_sdram_burst_colgen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] start_col = '0;
  logic [2:0] burst_len_code = '0;
  logic       burst_ilv = 1'b0, single_write = 1'b0;
  logic       stop_req = 1'b0, suspend = 1'b0;
  logic [7:0] col_addr;
  logic       beat_valid, last_beat, mode_err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .start_col(start_col), .burst_len_code(burst_len_code), .burst_ilv(burst_ilv),
    .single_write(single_write), .stop_req(stop_req), .suspend(suspend),
    .col_addr(col_addr), .beat_valid(beat_valid), .last_beat(last_beat),
    .mode_err(mode_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int i, input int L, input int ilv, input bit full);
    int base;
    if (full) return (s + i) % 256;
    if (ilv != 0) return s ^ i;
    base = s - (s % L);
    return base + ((s % L) + i) % L;
  endfunction

  // packed expectation: {valid, last, addr}
  function automatic int pk(input bit v, input bit l, input int a);
    return (int'(v) << 9) | (int'(l) << 8) | (a & 255);
  endfunction

  function automatic int now_pk();
    return pk(beat_valid, last_beat, col_addr);
  endfunction

  task automatic issue(input int code, input int ilv, input int sw, input int wr, input int s);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr[0]; start_col = s[7:0];
    burst_len_code = code[2:0]; burst_ilv = ilv[0]; single_write = sw[0];
  endtask

  task automatic do_burst(input int code, input int ilv, input int sw, input int wr, input int s, input string tag);
    int L;
    L = (wr != 0 && sw != 0) ? 1 : len_of(code);
    issue(code, ilv, sw, wr, s);
    for (int i = 0; i < L; i++) begin
      @(posedge clk); #1;
      chk(now_pk() == pk(1'b1, i == L - 1, exp_col(s, i, L, ilv, 1'b0)), tag, now_pk(),
          pk(1'b1, i == L - 1, exp_col(s, i, L, ilv, 1'b0)));
      @(negedge clk);
      if (i == 0) cmd_valid = 1'b0;
    end
    @(posedge clk); #1;
    chk(!beat_valid && !mode_err, {tag, " R6 end"}, {beat_valid, mode_err}, 0);
  endtask

  task automatic page_run(input int s, input int n);
    issue(7, 0, 0, 0, s);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk(now_pk() == pk(1'b1, 1'b0, (s + i) % 256), "R5 page beat", now_pk(), pk(1'b1, 1'b0, (s + i) % 256));
      @(negedge clk);
      if (i == 0) cmd_valid = 1'b0;
    end
    stop_req = 1'b1;
    @(posedge clk); #1;
    chk(!beat_valid && !mode_err, "R8 page stop", {beat_valid, mode_err}, 0);
    @(negedge clk); stop_req = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(posedge clk);
    #1;
    chk(now_pk() == 0 && !mode_err, "R13 reset", now_pk(), 0);
    @(negedge clk); rst = 1'b0;

    // exhaustive fixed-length sweep
    for (int code = 0; code < 4; code++)
      for (int ilv = 0; ilv < 2; ilv++)
        for (int sw = 0; sw < 2; sw++)
          for (int wr = 0; wr < 2; wr++)
            for (int s = 0; s < 256; s++)
              do_burst(code, ilv, sw, wr, s,
                (wr != 0 && sw != 0) ? "R10 single write" : (ilv != 0 ? "R4 R2 interleave" : "R3 R1 sequential"));

    // full page wrap
    page_run(0, 260);
    page_run(8'h5a, 258);
    page_run(8'hff, 3);

    // reserved codes
    for (int code = 4; code < 7; code++) begin
      issue(code, 0, 0, 0, 8'h10);
      @(posedge clk); #1;
      chk(!beat_valid && mode_err, "R1 reserved", {beat_valid, mode_err}, 1);
      @(negedge clk); cmd_valid = 1'b0;
      @(posedge clk); #1;
      chk(!mode_err && !beat_valid, "R1 reserved pulse", {beat_valid, mode_err}, 0);
    end
    // interleave with full page
    issue(7, 1, 0, 0, 8'h33);
    @(posedge clk); #1;
    chk(!beat_valid && mode_err, "R11 ilv page", {beat_valid, mode_err}, 1);
    @(negedge clk); cmd_valid = 1'b0;
    do_burst(7, 1, 1, 1, 8'h33, "R11 single write exception");

    // interrupt: 8-beat burst replaced after 3 beats
    issue(3, 0, 0, 0, 8'h13);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk(col_addr == 8'(exp_col(8'h13, i, 8, 0, 1'b0)), "R7 before", col_addr, exp_col(8'h13, i, 8, 0, 1'b0));
      @(negedge clk); cmd_valid = 1'b0;
    end
    do_burst(3, 1, 0, 0, 8'h42, "R7 interrupt");

    // illegal stop during fixed length
    issue(2, 0, 0, 0, 8'h86);
    @(posedge clk); #1;
    @(negedge clk); cmd_valid = 1'b0; stop_req = 1'b1;
    @(posedge clk); #1;
    chk(mode_err && beat_valid && col_addr == 8'h87, "R9 illegal stop", {mode_err, beat_valid, col_addr}, {2'b11, 8'h87});
    @(negedge clk); stop_req = 1'b0;
    @(posedge clk); #1;
    chk(now_pk() == pk(1'b1, 1'b0, 8'h84) && !mode_err, "R9 burst continues", now_pk(), pk(1'b1, 1'b0, 8'h84));
    @(posedge clk); #1;
    chk(now_pk() == pk(1'b1, 1'b1, 8'h85), "R9 last", now_pk(), pk(1'b1, 1'b1, 8'h85));
    @(posedge clk); #1;
    // idle stop
    @(negedge clk); stop_req = 1'b1;
    @(posedge clk); #1;
    chk(!beat_valid && !mode_err && col_addr == 8'h85, "R9 idle stop", {beat_valid, mode_err, col_addr}, 8'h85);
    @(negedge clk); stop_req = 1'b0;

    // suspend with ignored command and stop
    s0 = 8'h2d;
    issue(3, 0, 0, 0, s0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      @(negedge clk); cmd_valid = 1'b0;
    end
    suspend = 1'b1; cmd_valid = 1'b1; start_col = 8'h99; stop_req = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk(now_pk() == pk(1'b1, 1'b0, exp_col(s0, 2, 8, 0, 1'b0)), "R12 frozen", now_pk(),
          pk(1'b1, 1'b0, exp_col(s0, 2, 8, 0, 1'b0)));
    end
    @(negedge clk); suspend = 1'b0; cmd_valid = 1'b0; stop_req = 1'b0;
    for (int i = 3; i < 8; i++) begin
      @(posedge clk); #1;
      chk(now_pk() == pk(1'b1, i == 7, exp_col(s0, i, 8, 0, 1'b0)), "R12 resume", now_pk(),
          pk(1'b1, i == 7, exp_col(s0, i, 8, 0, 1'b0)));
    end
    @(posedge clk); #1;
    chk(!beat_valid, "R6 after resume", beat_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule